// File: doc/BRIEF.md
# 8-bit ALU with Flag Generation

This block is the purely combinational arithmetic and logic unit of a small accumulator-based processor core. It takes a register operand (normally the accumulator), a second operand (normally the memory or immediate byte), the incoming carry, the decimal-mode bit, an immediate-form qualifier and a 4-bit operation code. It returns an 8-bit result, candidate values for the Negative, Overflow, Zero and Carry flags, and a 4-bit mask that marks which of those flags the operation is allowed to change.

Add and subtract work on two's-complement bytes or, with decimal mode set, on two packed BCD digits. The operation set also has logical operations, a compare, a bit test, test-and-set and test-and-clear of memory bits, four shift and rotate forms, and increment and decrement. The surrounding core holds the registers: it writes `result` where the operation has a destination and copies each flag whose mask bit is set. Flag outputs whose mask bit is clear are driven low.

Top module: `alu8_core`

## Requirements
- R1: `op_sel` encodes 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 compare, 6 bit test, 7 test-and-set, 8 test-and-clear, 9 shift left, 10 shift right, 11 rotate left, 12 rotate right, 13 increment, 14 decrement; code 15 returns `op_a` as the result with a mask of 0.
- R2: `upd_mask` bit 3 is N, bit 2 is V, bit 1 is Z, bit 0 is C; each flag output is 0 whenever its mask bit is 0.
- R3: With `dec_mode` low, add gives `op_a + op_b + carry_in` modulo 256, C is the carry out of bit 7, V is the signed overflow, and the mask is 4'b1111.
- R4: With `dec_mode` low, subtract gives `op_a + ~op_b + carry_in`, so C is 1 exactly when no borrow occurs; V is the signed overflow of `op_a - op_b - (1 - carry_in)`; mask 4'b1111.
- R5: With `dec_mode` high and valid BCD operands, add returns the two-digit decimal sum `op_a + op_b + carry_in` modulo 100 with C set when the sum exceeds 99; V keeps its binary meaning.
- R6: With `dec_mode` high and valid BCD operands, subtract returns the decimal difference `op_a - op_b - (1 - carry_in)` wrapped modulo 100, with C cleared exactly when the difference is negative; V keeps its binary meaning.
- R7: AND, OR and XOR combine `op_a` with `op_b` and have mask 4'b1010.
- R8: Compare returns `op_a` unchanged as the result, sets C when `op_a >= op_b` (unsigned), Z when they are equal, N from bit 7 of `op_a - op_b`; mask 4'b1011.
- R9: Bit test returns `op_a`, sets Z when `op_a & op_b` is zero, N from `op_b[7]`, V from `op_b[6]`, mask 4'b1110; with `imm_form` high the mask is 4'b0010.
- R10: Test-and-set returns `op_b | op_a`, test-and-clear returns `op_b & ~op_a`; both set Z when `op_a & op_b` is zero and have mask 4'b0010.
- R11: Shift left returns `op_b << 1` with C = `op_b[7]`; shift right returns `op_b >> 1` with C = `op_b[0]` and N = 0; mask 4'b1011.
- R12: Rotate left returns `{op_b[6:0], carry_in}` with C = `op_b[7]`; rotate right returns `{carry_in, op_b[7:1]}` with C = `op_b[0]`; mask 4'b1011.
- R13: Increment and decrement return `op_b + 1` and `op_b - 1` modulo 256 with mask 4'b1010.
- R14: For every operation other than compare, bit test, test-and-set and test-and-clear, N equals bit 7 of `result` and Z is set exactly when `result` is zero, also in decimal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | Register operand (accumulator side) |
| op_b | input | 8 | Memory or immediate operand; target of shifts, increment and decrement |
| carry_in | input | 1 | Current carry flag |
| dec_mode | input | 1 | Decimal mode for add and subtract |
| imm_form | input | 1 | Bit test uses the immediate form |
| op_sel | input | 4 | Operation code |
| result | output | 8 | Operation result |
| n_out | output | 1 | New N value |
| v_out | output | 1 | New V value |
| z_out | output | 1 | New Z value |
| c_out | output | 1 | New C value |
| upd_mask | output | 4 | Flags the operation changes: N, V, Z, C from bit 3 down |

## Verification
The assertions watch properties that hold for any input: decimal results stay valid BCD digits, binary subtract carry agrees with an unsigned comparison, rotates conserve the count of ones across result and carry, Z tracks a zero result, shift right never raises N, and only arithmetic or the memory form of bit test may touch V. The exact values of the decimal correction, the signed overflow cases, the compare boundaries at equal and wrapping operands, and the immediate bit test mask are only shown by the bench's directed scenarios against its own integer model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_CMP  = 4'd5,
    OP_TEST = 4'd6,
    OP_SETB = 4'd7,
    OP_CLRB = 4'd8,
    OP_SHL  = 4'd9,
    OP_SHR  = 4'd10,
    OP_ROTL = 4'd11,
    OP_ROTR = 4'd12,
    OP_INCR = 4'd13,
    OP_DECR = 4'd14,
    OP_PASS = 4'd15
  } alu_op_e;

  // Positions of the flags in the update mask
  localparam int FLG_N = 3;
  localparam int FLG_V = 2;
  localparam int FLG_Z = 1;
  localparam int FLG_C = 0;

  localparam logic [3:0] MASK_ALL   = 4'b1111;
  localparam logic [3:0] MASK_NZ    = 4'b1010;
  localparam logic [3:0] MASK_NZC   = 4'b1011;
  localparam logic [3:0] MASK_NVZ   = 4'b1110;
  localparam logic [3:0] MASK_Z     = 4'b0010;
  localparam logic [3:0] MASK_NONE  = 4'b0000;

  typedef struct packed {
    logic [3:0] dig;
    logic       cy;
  } bcd_digit_t;

  // One packed-BCD digit step. For subtract, cy_i = 1 means no borrow in
  // and the returned cy = 1 means no borrow out.
  function automatic bcd_digit_t bcd_digit_step(input logic [3:0] x,
                                                input logic [3:0] y,
                                                input logic       cy_i,
                                                input logic       sub);
    logic [4:0] raw;
    bcd_digit_t o;
    if (!sub) begin
      raw = {1'b0, x} + {1'b0, y} + {4'b0000, cy_i};
      if (raw > 5'd9) begin
        o.dig = raw[3:0] + 4'd6;
        o.cy  = 1'b1;
      end else begin
        o.dig = raw[3:0];
        o.cy  = 1'b0;
      end
    end else begin
      raw = {1'b0, x} - {1'b0, y} - {4'b0000, ~cy_i};
      if (raw[4]) begin
        o.dig = raw[3:0] - 4'd6;
        o.cy  = 1'b0;
      end else begin
        o.dig = raw[3:0];
        o.cy  = 1'b1;
      end
    end
    return o;
  endfunction

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic             sub_i,
  input  logic             dec_i,
  output logic [WIDTH-1:0] res_o,
  output logic             c_o,
  output logic             v_o
);
  localparam int DIGITS = WIDTH / 4;

  function automatic logic is_bcd(input logic [WIDTH-1:0] val);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < DIGITS; k++) begin
      if (val[4*k +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  // Binary path: subtract is an add of the inverted operand
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   bin_sum;
  logic             bin_ovf;

  assign b_eff   = sub_i ? ~b_i : b_i;
  assign bin_sum = {1'b0, a_i} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin_i};
  assign bin_ovf = (a_i[WIDTH-1] == b_eff[WIDTH-1]) &&
                   (bin_sum[WIDTH-1] != a_i[WIDTH-1]);

  // Decimal path: ripple of digit steps
  logic [DIGITS:0]  dcy;
  logic [WIDTH-1:0] dec_sum;

  assign dcy[0] = cin_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    bcd_digit_t step;
    assign step               = bcd_digit_step(a_i[4*g +: 4], b_i[4*g +: 4], dcy[g], sub_i);
    assign dec_sum[4*g +: 4]  = step.dig;
    assign dcy[g+1]           = step.cy;
  end

  assign res_o = dec_i ? dec_sum : bin_sum[WIDTH-1:0];
  assign c_o   = dec_i ? dcy[DIGITS] : bin_sum[WIDTH];
  assign v_o   = bin_ovf;

  // R5/R6: valid digits in give valid digits out
  always_comb begin
    if (dec_i && is_bcd(a_i) && is_bcd(b_i)) begin
      a_r5_digits_valid: assert (is_bcd(res_o))
        else $error("decimal result holds a digit above nine");
    end
  end

  // R4: with no borrow in, binary subtract carry equals unsigned a >= b
  always_comb begin
    if (!dec_i && sub_i && cin_i) begin
      a_r4_no_borrow: assert (c_o == (a_i >= b_i))
        else $error("subtract carry disagrees with operand order");
    end
  end

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             and_zero_o
);
  logic [WIDTH-1:0] common;

  assign common     = a_i & b_i;
  assign and_zero_o = (common == '0);

  always_comb begin
    unique case (op_i)
      OP_AND:  res_o = common;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_SETB: res_o = b_i | a_i;
      OP_CLRB: res_o = b_i & ~a_i;
      default: res_o = a_i;
    endcase
  end

  // R10: test-and-clear never leaves a bit set that the register selects
  always_comb begin
    if (op_i == OP_CLRB) begin
      a_r10_clear_disjoint: assert ((res_o & a_i) == '0)
        else $error("test-and-clear left a selected bit set");
    end
  end

endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  alu_op_e          op_i,
  output logic [WIDTH-1:0] res_o,
  output logic             cout_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    res_o  = b_i;
    cout_o = 1'b0;
    unique case (op_i)
      OP_SHL: begin
        res_o  = {b_i[MSB-1:0], 1'b0};
        cout_o = b_i[MSB];
      end
      OP_SHR: begin
        res_o  = {1'b0, b_i[MSB:1]};
        cout_o = b_i[0];
      end
      OP_ROTL: begin
        res_o  = {b_i[MSB-1:0], cin_i};
        cout_o = b_i[MSB];
      end
      OP_ROTR: begin
        res_o  = {cin_i, b_i[MSB:1]};
        cout_o = b_i[0];
      end
      OP_INCR: res_o = b_i + {{(WIDTH-1){1'b0}}, 1'b1};
      OP_DECR: res_o = b_i - {{(WIDTH-1){1'b0}}, 1'b1};
      default: ;
    endcase
  end

  // R12: a rotate through carry keeps the number of ones
  always_comb begin
    if (op_i == OP_ROTL || op_i == OP_ROTR) begin
      a_r12_rot_conserve: assert ($countones({res_o, cout_o}) == $countones({b_i, cin_i}))
        else $error("rotate lost or gained a bit");
    end
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             carry_in,
  input  logic             dec_mode,
  input  logic             imm_form,
  input  logic [3:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             n_out,
  output logic             v_out,
  output logic             z_out,
  output logic             c_out,
  output logic [3:0]       upd_mask
);
  localparam int MSB = WIDTH - 1;

  alu_op_e op;
  assign op = alu_op_e'(op_sel);

  // Named internal events
  logic is_arith;
  logic is_logic;
  logic is_shift;
  logic is_bitop;
  logic z_from_result;

  assign is_arith      = (op == OP_ADD) || (op == OP_SUB);
  assign is_logic      = (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  assign is_bitop      = (op == OP_TEST) || (op == OP_SETB) || (op == OP_CLRB);
  assign is_shift      = (op == OP_SHL) || (op == OP_SHR) || (op == OP_ROTL) ||
                         (op == OP_ROTR) || (op == OP_INCR) || (op == OP_DECR);
  assign z_from_result = !is_bitop && (op != OP_CMP);

  // Datapath units
  logic [WIDTH-1:0] as_res, lg_res, sh_res;
  logic             as_c, as_v, sh_c, and_zero;

  alu8_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (op_a),
    .b_i   (op_b),
    .cin_i (carry_in),
    .sub_i (op == OP_SUB),
    .dec_i (dec_mode),
    .res_o (as_res),
    .c_o   (as_c),
    .v_o   (as_v)
  );

  alu8_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i        (op_a),
    .b_i        (op_b),
    .op_i       (op),
    .res_o      (lg_res),
    .and_zero_o (and_zero)
  );

  alu8_shift #(.WIDTH(WIDTH)) u_shift (
    .b_i    (op_b),
    .cin_i  (carry_in),
    .op_i   (op),
    .res_o  (sh_res),
    .cout_o (sh_c)
  );

  // Compare: register minus operand with no borrow in
  logic [WIDTH:0] cmp_diff;
  assign cmp_diff = {1'b0, op_a} + {1'b0, ~op_b} + {{WIDTH{1'b0}}, 1'b1};

  // Result and raw flag selection
  logic             n_raw, v_raw, z_raw, c_raw;
  logic [3:0]       mask;

  always_comb begin
    result = op_a;
    v_raw  = 1'b0;
    c_raw  = 1'b0;
    n_raw  = 1'b0;
    z_raw  = 1'b0;
    mask   = MASK_NONE;
    if (is_arith) begin
      result = as_res;
      v_raw  = as_v;
      c_raw  = as_c;
      mask   = MASK_ALL;
    end else if (is_logic) begin
      result = lg_res;
      mask   = MASK_NZ;
    end else if (is_shift) begin
      result = sh_res;
      c_raw  = sh_c;
      mask   = (op == OP_INCR || op == OP_DECR) ? MASK_NZ : MASK_NZC;
    end else if (op == OP_CMP) begin
      n_raw  = cmp_diff[MSB];
      z_raw  = (cmp_diff[MSB:0] == '0);
      c_raw  = cmp_diff[WIDTH];
      mask   = MASK_NZC;
    end else if (op == OP_TEST) begin
      n_raw  = op_b[MSB];
      v_raw  = op_b[MSB-1];
      z_raw  = and_zero;
      mask   = imm_form ? MASK_Z : MASK_NVZ;
    end else if (op == OP_SETB || op == OP_CLRB) begin
      result = lg_res;
      z_raw  = and_zero;
      mask   = MASK_Z;
    end
    if (z_from_result) begin
      n_raw = result[MSB];
      z_raw = (result == '0);
    end
  end

  assign upd_mask = mask;
  assign n_out    = n_raw & mask[FLG_N];
  assign v_out    = v_raw & mask[FLG_V];
  assign z_out    = z_raw & mask[FLG_Z];
  assign c_out    = c_raw & mask[FLG_C];

  // R8: compare leaves the register value on the result bus
  always_comb begin
    if (op == OP_CMP) begin
      a_r8_cmp_keeps: assert (result == op_a)
        else $error("compare altered the result");
    end
  end

  // R14: Z follows a zero result for result-driven operations
  always_comb begin
    if (z_from_result && mask[FLG_Z]) begin
      a_r14_z_tracks: assert (z_out == (result == '0))
        else $error("Z disagrees with result");
    end
  end

  // R11: shift right never raises N
  always_comb begin
    if (op == OP_SHR) begin
      a_r11_shr_clears_n: assert (!n_out)
        else $error("shift right produced N");
    end
  end

  // R9: only arithmetic or the memory form of bit test may touch V
  always_comb begin
    if (upd_mask[FLG_V]) begin
      a_r9_v_owner: assert (is_arith || (op == OP_TEST && !imm_form))
        else $error("V enabled for a foreign operation");
    end
  end

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] op_a = 8'h00;
  logic [7:0] op_b = 8'h00;
  logic       carry_in = 1'b0;
  logic       dec_mode = 1'b0;
  logic       imm_form = 1'b0;
  logic [3:0] op_sel = 4'd15;
  logic [7:0] result;
  logic       n_out, v_out, z_out, c_out;
  logic [3:0] upd_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  alu8_core dut (
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .dec_mode (dec_mode),
    .imm_form (imm_form),
    .op_sel   (op_sel),
    .result   (result),
    .n_out    (n_out),
    .v_out    (v_out),
    .z_out    (z_out),
    .c_out    (c_out),
    .upd_mask (upd_mask)
  );

  // ---------------- independent model ----------------
  function automatic bit sovf(input int t);
    return (t > 127) || (t < -128);
  endfunction

  function automatic int bcd2i(input logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  function automatic logic [7:0] i2bcd(input int s);
    return 8'((s / 10) * 16 + (s % 10));
  endfunction

  // Packs {result, N, V, Z, C, mask}
  function automatic logic [15:0] model(input logic [3:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic c,
                                        input logic d, input logic imm);
    int s;
    int sa, sb, ci;
    logic [7:0] r;
    logic n, v, z, cy, zres;
    logic [3:0] m;
    r = a; n = 0; v = 0; z = 0; cy = 0; m = 4'b0000; zres = 1;
    sa = int'($signed(a)); sb = int'($signed(b)); ci = int'(c);
    case (op)
      4'd0: begin
        m = 4'b1111; v = sovf(sa + sb + ci);
        if (d) begin s = bcd2i(a) + bcd2i(b) + ci; cy = (s > 99); r = i2bcd(s % 100); end
        else begin s = int'(a) + int'(b) + ci; cy = (s > 255); r = s[7:0]; end
      end
      4'd1: begin
        m = 4'b1111; v = sovf(sa - sb - (1 - ci));
        if (d) begin
          s = bcd2i(a) - bcd2i(b) - (1 - ci); cy = (s >= 0);
          if (s < 0) s = s + 100;
          r = i2bcd(s);
        end else begin
          s = int'(a) - int'(b) - (1 - ci); cy = (s >= 0);
          if (s < 0) s = s + 256;
          r = s[7:0];
        end
      end
      4'd2: begin r = a & b; m = 4'b1010; end
      4'd3: begin r = a | b; m = 4'b1010; end
      4'd4: begin r = a ^ b; m = 4'b1010; end
      4'd5: begin
        s = int'(a) - int'(b); if (s < 0) s = s + 256;
        n = s[7]; z = (a == b); cy = (a >= b); m = 4'b1011; zres = 0;
      end
      4'd6: begin
        z = ((a & b) == 8'h00); n = b[7]; v = b[6];
        m = imm ? 4'b0010 : 4'b1110; zres = 0;
      end
      4'd7: begin r = b | a;  z = ((a & b) == 8'h00); m = 4'b0010; zres = 0; end
      4'd8: begin r = b & ~a; z = ((a & b) == 8'h00); m = 4'b0010; zres = 0; end
      4'd9:  begin r = {b[6:0], 1'b0}; cy = b[7]; m = 4'b1011; end
      4'd10: begin r = {1'b0, b[7:1]}; cy = b[0]; m = 4'b1011; end
      4'd11: begin r = {b[6:0], c};    cy = b[7]; m = 4'b1011; end
      4'd12: begin r = {c, b[7:1]};    cy = b[0]; m = 4'b1011; end
      4'd13: begin s = int'(b) + 1; r = s[7:0]; m = 4'b1010; end
      4'd14: begin s = int'(b) + 255; r = s[7:0]; m = 4'b1010; end
      default: begin r = a; m = 4'b0000; zres = 0; end
    endcase
    if (zres) begin n = r[7]; z = (r == 8'h00); end
    return {r, n & m[3], v & m[2], z & m[1], cy & m[0], m};
  endfunction

  // ---------------- drive and check ----------------
  task automatic run(input string req, input logic [3:0] op, input logic [7:0] a,
                     input logic [7:0] b, input logic c, input logic d, input logic imm);
    logic [15:0] got, exp;
    @(posedge clk);
    #1;
    op_sel = op; op_a = a; op_b = b; carry_in = c; dec_mode = d; imm_form = imm;
    @(negedge clk);
    got = {result, n_out, v_out, z_out, c_out, upd_mask};
    exp = model(op, a, b, c, d, imm);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h c=%b d=%b imm=%b: got res=%h nvzc=%b mask=%b, expected res=%h nvzc=%b mask=%b",
               req, op, a, b, c, d, imm, got[15:8], got[7:4], got[3:0],
               exp[15:8], exp[7:4], exp[3:0]);
    end
  endtask

  task automatic check_literal(input string req, input logic [15:0] exp);
    logic [15:0] got;
    got = {result, n_out, v_out, z_out, c_out, upd_mask};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic t_idle;
    // R1: code 15 passes op_a with no flag updates (state during reset)
    @(negedge clk);
    check_literal("R1 idle pass", {8'h00, 4'b0000, 4'b0000});
    run("R1 pass code", 4'd15, 8'hA5, 8'h3C, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_bin_add;
    run("R3 add simple",   4'd0, 8'h12, 8'h34, 1'b0, 1'b0, 1'b0);
    run("R3 add overflow", 4'd0, 8'h50, 8'h50, 1'b0, 1'b0, 1'b0);
    run("R3 add wrap zero",4'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0);
    run("R3 add carry in", 4'd0, 8'h7F, 8'h00, 1'b1, 1'b0, 1'b0);
    run("R3 add neg ovf",  4'd0, 8'h80, 8'hFF, 1'b0, 1'b0, 1'b0);
    // R14 Z from sum zero
    run("R14 add zero",    4'd0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_bin_sub;
    run("R4 sub no borrow", 4'd1, 8'h50, 8'h20, 1'b1, 1'b0, 1'b0);
    run("R4 sub borrow",    4'd1, 8'h20, 8'h50, 1'b1, 1'b0, 1'b0);
    run("R4 sub borrow in", 4'd1, 8'h20, 8'h20, 1'b0, 1'b0, 1'b0);
    run("R4 sub equal",     4'd1, 8'h20, 8'h20, 1'b1, 1'b0, 1'b0);
    run("R4 sub overflow",  4'd1, 8'h80, 8'h01, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_dec_add;
    run("R5 dadd plain",     4'd0, 8'h12, 8'h34, 1'b0, 1'b1, 1'b0);
    run("R5 dadd fix both",  4'd0, 8'h58, 8'h46, 1'b1, 1'b1, 1'b0);
    run("R5 dadd to zero",   4'd0, 8'h99, 8'h01, 1'b0, 1'b1, 1'b0);
    run("R5 dadd low fix",   4'd0, 8'h09, 8'h01, 1'b0, 1'b1, 1'b0);
    run("R5 dadd max",       4'd0, 8'h99, 8'h99, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_dec_sub;
    run("R6 dsub plain",     4'd1, 8'h46, 8'h12, 1'b1, 1'b1, 1'b0);
    run("R6 dsub wrap",      4'd1, 8'h12, 8'h21, 1'b1, 1'b1, 1'b0);
    run("R6 dsub borrow in", 4'd1, 8'h00, 8'h00, 1'b0, 1'b1, 1'b0);
    run("R6 dsub low borrow",4'd1, 8'h40, 8'h01, 1'b1, 1'b1, 1'b0);
    run("R6 dsub zero",      4'd1, 8'h37, 8'h37, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_logic;
    run("R7 and",      4'd2, 8'hF0, 8'h3C, 1'b1, 1'b0, 1'b0);
    run("R7 and zero", 4'd2, 8'hF0, 8'h0F, 1'b0, 1'b0, 1'b0);
    run("R7 or",       4'd3, 8'h81, 8'h02, 1'b0, 1'b0, 1'b0);
    run("R7 xor",      4'd4, 8'hAA, 8'hAA, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_compare;
    run("R8 cmp greater", 4'd5, 8'h40, 8'h30, 1'b0, 1'b0, 1'b0);
    run("R8 cmp equal",   4'd5, 8'h40, 8'h40, 1'b0, 1'b0, 1'b0);
    run("R8 cmp less",    4'd5, 8'h30, 8'h40, 1'b1, 1'b0, 1'b0);
    run("R8 cmp wide",    4'd5, 8'hFF, 8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_bittest;
    run("R9 bit memory",      4'd6, 8'h01, 8'hC0, 1'b0, 1'b0, 1'b0);
    run("R9 bit memory nz",   4'd6, 8'h41, 8'h41, 1'b1, 1'b0, 1'b0);
    run("R9 bit immediate",   4'd6, 8'h01, 8'hC0, 1'b0, 1'b0, 1'b1);
    run("R2 unmasked low",    4'd6, 8'hFF, 8'hC1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_setclr;
    run("R10 set overlap",   4'd7, 8'h0F, 8'h31, 1'b0, 1'b0, 1'b0);
    run("R10 set disjoint",  4'd7, 8'h0F, 8'hF0, 1'b1, 1'b0, 1'b0);
    run("R10 clr overlap",   4'd8, 8'h0F, 8'h3F, 1'b0, 1'b0, 1'b0);
    run("R10 clr disjoint",  4'd8, 8'h0F, 8'hF0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_shifts;
    run("R11 shl carry",  4'd9,  8'h00, 8'h81, 1'b0, 1'b0, 1'b0);
    run("R11 shl zero",   4'd9,  8'h00, 8'h80, 1'b1, 1'b0, 1'b0);
    run("R11 shr carry",  4'd10, 8'h00, 8'h81, 1'b1, 1'b0, 1'b0);
    run("R11 shr one",    4'd10, 8'h00, 8'h01, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_rotates;
    run("R12 rotl cin",   4'd11, 8'h00, 8'h80, 1'b1, 1'b0, 1'b0);
    run("R12 rotl zero",  4'd11, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0);
    run("R12 rotr cin",   4'd12, 8'h00, 8'h01, 1'b1, 1'b0, 1'b0);
    run("R12 rotr plain", 4'd12, 8'h00, 8'h6A, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_incdec;
    run("R13 inc wrap",  4'd13, 8'h00, 8'hFF, 1'b1, 1'b0, 1'b0);
    run("R13 inc sign",  4'd13, 8'h00, 8'h7F, 1'b0, 1'b0, 1'b0);
    run("R13 dec wrap",  4'd14, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    run("R13 dec one",   4'd14, 8'h00, 8'h01, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_sweep;
    // R2 R14: every code over a spread of binary operands
    logic [7:0] a, b;
    a = 8'h5B; b = 8'hC3;
    for (int i = 0; i < 160; i++) begin
      a = {a[6:0], a[7] ^ a[5] ^ a[4] ^ a[3]};
      b = b + 8'h3B;
      run("R2 sweep", 4'(i % 16), a, b, 1'(i / 16), 1'b0, 1'(i / 3));
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    t_idle();
    rst_n = 1'b1;
    t_bin_add();
    t_bin_sub();
    t_dec_add();
    t_dec_sub();
    t_logic();
    t_compare();
    t_bittest();
    t_setclr();
    t_shifts();
    t_rotates();
    t_incdec();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule